// File: doc/BRIEF.md
# Random Port Command and Byte-Lane Decoder

This block sits on the random-access side of a 4096 x 16 shared buffer. One set of address and data pins serves two targets. With the array enable low, a cycle reaches the storage array. In that case the upper and lower byte lanes are enabled separately for both writes and reads. With the command enable low, the low three address bits select one of eight command registers instead. These registers hold the start and end pointers of two buffers and a control word. They also hold a read-only view of the two end-of-buffer flags, which the pointer block keeps.

The array itself lives outside the block. The block hands the array an address, write data and one write enable per byte lane, and it takes back the read word. Register contents go continuously to the pointer block. A write to the control word that holds a zero in bit 0 or bit 1 also pulses a clear request for the matching flag. Writes take effect on a rising clock edge while a synchronous write strobe is high. Read data appears combinationally. Every output bit has its own drive enable, which stands in for a tri-state driver.

Top module: `rap_port`

## Requirements
- R1: Array write: when array enable is low, command enable is high, `rw` is 0 and `wr_stb` is 1, `arr_we_o[0]` is 1 exactly when `lb_n` is 0 and `arr_we_o[1]` exactly when `ub_n` is 0. `arr_addr_o` follows `addr` and `arr_wdata_o` follows `din`.
- R2: Array read: with array enable low, command enable high, `rw` 1 and `oe_n` 0, lane 0 (bits 7:0) shows `arr_rdata_i` and is driven only if `lb_n` is 0. Lane 1 (bits 15:8) behaves the same way under `ub_n`. An undriven lane reads 0 with its enables 0.
- R3: `dout_en` is all zero, and `dout` is zero, whenever `oe_n` is 1 or `rw` is 0.
- R4: With both enables high the port is idle: no output bit is driven, no array lane is written, and no register changes.
- R5: With both enables low at once, `conflict_o` is 1, no array lane is written, no register changes and nothing is driven.
- R6: A register write (array enable high, command enable low, `rw` 0, `wr_stb` 1) to code 0, 1, 2 or 3 stores `din[11:0]` into start 1, end 1, start 2 or end 2. The stored value appears on the matching output after the edge and reads back with bits 15:12 zero.
- R7: A register write to code 5 stores `din[12:0]` in the control word, shown on `ctl_o` and read back with bits 15:13 zero.
- R8: During a register write to code 5, `flag_clr_o[0]` is 1 when `din[0]` is 0 and `flag_clr_o[1]` is 1 when `din[1]` is 0. In every other cycle both are 0.
- R9: Code 6 reads `flag_i` in bits 1:0 and zero above. Codes 4, 6 and 7 ignore writes, and codes 4 and 7 read as zero.
- R10: While `rst_n` is low at a rising edge, every register is cleared to zero.
- R11: A register read drives all 16 bits regardless of `lb_n` and `ub_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for register capture |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | Write strobe sampled on the rising edge |
| ce_n | input | 1 | Array enable, active low |
| cmd_n | input | 1 | Command register enable, active low |
| rw | input | 1 | 1 = read, 0 = write |
| oe_n | input | 1 | Output enable, active low |
| lb_n | input | 1 | Lower byte lane enable, active low |
| ub_n | input | 1 | Upper byte lane enable, active low |
| addr | input | 12 | Word address; bits 2:0 pick a register in command mode |
| din | input | 16 | Write data |
| dout | output | 16 | Read data, zero where not driven |
| dout_en | output | 16 | Per-bit output drive enable |
| conflict_o | output | 1 | Both enables low at once |
| arr_addr_o | output | 12 | Array address |
| arr_wdata_o | output | 16 | Array write data |
| arr_we_o | output | 2 | Array write enable per byte lane |
| arr_rdata_i | input | 16 | Array read data |
| start1_o | output | 12 | Buffer 1 start pointer |
| end1_o | output | 12 | Buffer 1 end pointer |
| start2_o | output | 12 | Buffer 2 start pointer |
| end2_o | output | 12 | Buffer 2 end pointer |
| ctl_o | output | 13 | Control word |
| flag_clr_o | output | 2 | End-flag clear request per buffer |
| flag_i | input | 2 | End-flag status from the pointer block |

## Verification
A wrong mode decode shows up in the same cycle. A byte lane can be written or driven that should stay quiet, or a collision can slip a write through, and the per-lane enables reveal either at once. A register that latches the wrong code or the wrong bits shows on its dedicated output one edge after the write, so every write is followed by a check of all pointer outputs and by a readback. A wrong flag-clear decode is visible only while the strobe is high, so clear requests are sampled before the capturing edge.

// File: rtl/rap_pkg.sv
// Shared types and register codes for the random port decoder.
// Assumes: register codes are fixed behaviour; buffer count is two.
package rap_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'd0,
        MODE_ARRAY = 2'd1,
        MODE_CMD   = 2'd2,
        MODE_CLASH = 2'd3
    } rap_mode_e;

    localparam int unsigned REG_AW   = 3;
    localparam int unsigned NBUF     = 2;
    localparam logic [REG_AW-1:0] CODE_CTL  = 3'd5;
    localparam logic [REG_AW-1:0] CODE_FLAG = 3'd6;

endpackage

// File: rtl/rap_decode.sv
// Mode decoder: classifies a cycle from the two active-low enables.
// Assumes: enables are stable for the cycle; a collision is a legal input
// that must be reported and made harmless.
module rap_decode
    import rap_pkg::*;
(
    input  logic      ce_n,
    input  logic      cmd_n,
    output rap_mode_e mode,
    output logic      conflict
);

    // Pick the target of the current cycle.
    always_comb begin
        unique case ({ce_n, cmd_n})
            2'b01:   mode = MODE_ARRAY;
            2'b10:   mode = MODE_CMD;
            2'b00:   mode = MODE_CLASH;
            default: mode = MODE_IDLE;
        endcase
    end

    // Collision flag for the outside world.
    assign conflict = (mode == MODE_CLASH);

endmodule

// File: rtl/rap_regfile.sv
// Command register file: start/end pointers for each buffer, a control
// word and a read-only flag view. Writes are captured on the clock edge.
// Assumes: wr_en is already qualified by mode, direction and strobe.
module rap_regfile
    import rap_pkg::*;
#(
    parameter int unsigned PTR_W = 12,
    parameter int unsigned CTL_W = 13
)(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [REG_AW-1:0]          sel,
    input  logic [CTL_W-1:0]           wdata,
    input  logic [NBUF-1:0]            flag_i,
    output logic [NBUF-1:0][PTR_W-1:0] start_o,
    output logic [NBUF-1:0][PTR_W-1:0] end_o,
    output logic [CTL_W-1:0]           ctl_o,
    output logic [CTL_W-1:0]           rdata,
    output logic [NBUF-1:0]            flag_clr_o
);

    logic [NBUF-1:0][PTR_W-1:0] start_q;
    logic [NBUF-1:0][PTR_W-1:0] end_q;
    logic [CTL_W-1:0]           ctl_q;
    logic                       ctl_hit;

    assign ctl_hit = wr_en && (sel == CODE_CTL);

    for (genvar b = 0; b < NBUF; b++) begin : g_buf
        localparam logic [REG_AW-1:0] CODE_START = REG_AW'(2 * b);
        localparam logic [REG_AW-1:0] CODE_END   = REG_AW'(2 * b + 1);

        // Start pointer of buffer b.
        always_ff @(posedge clk) begin
            if (!rst_n)
                start_q[b] <= '0;
            else if (wr_en && sel == CODE_START)
                start_q[b] <= wdata[PTR_W-1:0];
        end

        // End pointer of buffer b.
        always_ff @(posedge clk) begin
            if (!rst_n)
                end_q[b] <= '0;
            else if (wr_en && sel == CODE_END)
                end_q[b] <= wdata[PTR_W-1:0];
        end

        // A zero in the matching control bit asks for a flag clear.
        assign flag_clr_o[b] = ctl_hit && !wdata[b];

        AST_START_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && sel == CODE_START) |=> $stable(start_q[b])); // R6
        AST_END_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && sel == CODE_END) |=> $stable(end_q[b])); // R6
    end

    // Control word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= '0;
        else if (ctl_hit)
            ctl_q <= wdata;
    end

    // Readback multiplexer; unmapped codes read as zero.
    always_comb begin
        rdata = '0;
        for (int b = 0; b < NBUF; b++) begin
            if (sel == REG_AW'(2 * b))     rdata = CTL_W'(start_q[b]);
            if (sel == REG_AW'(2 * b + 1)) rdata = CTL_W'(end_q[b]);
        end
        if (sel == CODE_CTL)  rdata = ctl_q;
        if (sel == CODE_FLAG) rdata = CTL_W'(flag_i);
    end

    assign start_o = start_q;
    assign end_o   = end_q;
    assign ctl_o   = ctl_q;

    AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_hit |=> $stable(ctl_q)); // R7

endmodule

// File: rtl/rap_lane.sv
// One byte lane: write enable toward the array and output drive for reads.
// Assumes: register reads ignore the lane enable and drive the whole lane.
module rap_lane #(
    parameter int unsigned LANE_W = 8
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lane_en_n,
    input  logic              arr_sel,
    input  logic              cmd_sel,
    input  logic              wr_stb,
    input  logic              rw,
    input  logic              oe_n,
    input  logic [LANE_W-1:0] arr_rd,
    input  logic [LANE_W-1:0] cmd_rd,
    output logic              we,
    output logic [LANE_W-1:0] dout,
    output logic [LANE_W-1:0] dout_en
);

    logic drive;

    // Array write for this lane.
    assign we = wr_stb && arr_sel && !rw && !lane_en_n;

    // Output drive: reads only, with output enable asserted.
    assign drive = !oe_n && rw && (cmd_sel || (arr_sel && !lane_en_n));

    // Data selection, zero when not driven.
    always_comb begin
        if (!drive)       dout = '0;
        else if (cmd_sel) dout = cmd_rd;
        else              dout = arr_rd;
    end

    assign dout_en = {LANE_W{drive}};

    AST_LANE_WE_EN: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (!lane_en_n && dout_en == '0)); // R1
    AST_LANE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_en == '0) |-> (dout == '0)); // R2

endmodule

// File: rtl/rap_port.sv
// Random-access port: decodes array versus command cycles, splits byte
// lanes, hosts the command register file and gates the outputs.
// Assumes: the array captures on the same clock edge when arr_we_o is high.
module rap_port
    import rap_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned LANE_W = 8,
    parameter int unsigned CTL_W  = 13
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              ce_n,
    input  logic              cmd_n,
    input  logic              rw,
    input  logic              oe_n,
    input  logic              lb_n,
    input  logic              ub_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic [DATA_W-1:0] dout_en,
    output logic              conflict_o,
    output logic [ADDR_W-1:0] arr_addr_o,
    output logic [DATA_W-1:0] arr_wdata_o,
    output logic [1:0]        arr_we_o,
    input  logic [DATA_W-1:0] arr_rdata_i,
    output logic [ADDR_W-1:0] start1_o,
    output logic [ADDR_W-1:0] end1_o,
    output logic [ADDR_W-1:0] start2_o,
    output logic [ADDR_W-1:0] end2_o,
    output logic [CTL_W-1:0]  ctl_o,
    output logic [1:0]        flag_clr_o,
    input  logic [1:0]        flag_i
);

    localparam int unsigned NLANE = DATA_W / LANE_W;

    rap_mode_e                   mode;
    logic                        arr_sel;
    logic                        cmd_sel;
    logic                        reg_wr;
    logic [CTL_W-1:0]            reg_rd;
    logic [DATA_W-1:0]           reg_rd_ext;
    logic [NLANE-1:0]            lane_en_n;
    logic [NBUF-1:0][ADDR_W-1:0] start_w;
    logic [NBUF-1:0][ADDR_W-1:0] end_w;

    rap_decode u_decode (
        .ce_n     (ce_n),
        .cmd_n    (cmd_n),
        .mode     (mode),
        .conflict (conflict_o)
    );

    assign arr_sel = (mode == MODE_ARRAY);
    assign cmd_sel = (mode == MODE_CMD);

    // Register write is a command cycle with write direction and strobe.
    assign reg_wr = cmd_sel && !rw && wr_stb;

    rap_regfile #(
        .PTR_W (ADDR_W),
        .CTL_W (CTL_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .sel        (addr[REG_AW-1:0]),
        .wdata      (din[CTL_W-1:0]),
        .flag_i     (flag_i),
        .start_o    (start_w),
        .end_o      (end_w),
        .ctl_o      (ctl_o),
        .rdata      (reg_rd),
        .flag_clr_o (flag_clr_o)
    );

    assign reg_rd_ext = DATA_W'(reg_rd);
    assign lane_en_n  = {ub_n, lb_n};

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        rap_lane #(.LANE_W(LANE_W)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .lane_en_n (lane_en_n[l]),
            .arr_sel   (arr_sel),
            .cmd_sel   (cmd_sel),
            .wr_stb    (wr_stb),
            .rw        (rw),
            .oe_n      (oe_n),
            .arr_rd    (arr_rdata_i[l*LANE_W +: LANE_W]),
            .cmd_rd    (reg_rd_ext[l*LANE_W +: LANE_W]),
            .we        (arr_we_o[l]),
            .dout      (dout[l*LANE_W +: LANE_W]),
            .dout_en   (dout_en[l*LANE_W +: LANE_W])
        );
    end

    // Array address and data pass straight through.
    assign arr_addr_o  = addr;
    assign arr_wdata_o = din;

    assign start1_o = start_w[0];
    assign end1_o   = end_w[0];
    assign start2_o = start_w[1];
    assign end2_o   = end_w[1];

    AST_CLASH_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        conflict_o |-> (arr_we_o == '0 && flag_clr_o == '0 && dout_en == '0)); // R5
    AST_NO_DRIVE_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (!rw || oe_n) |-> (dout_en == '0)); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && cmd_n) |-> (dout_en == '0 && arr_we_o == '0)); // R4
    AST_CLR_CMD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_o != '0) |-> (!cmd_n && ce_n && !rw && wr_stb)); // R8
    AST_REG_NO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_sel && rw && !oe_n) |-> (dout_en == '1 && arr_we_o == '0)); // R11

endmodule

// File: tb/rap_port_tb_top.sv
module rap_port_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic        ce_n = 1'b1;
    logic        cmd_n = 1'b1;
    logic        rw = 1'b1;
    logic        oe_n = 1'b1;
    logic        lb_n = 1'b1;
    logic        ub_n = 1'b1;
    logic [11:0] addr = '0;
    logic [15:0] din = '0;
    logic [15:0] dout, dout_en;
    logic        conflict_o;
    logic [11:0] arr_addr_o;
    logic [15:0] arr_wdata_o;
    logic [1:0]  arr_we_o;
    logic [15:0] arr_rdata_i = '0;
    logic [11:0] start1_o, end1_o, start2_o, end2_o;
    logic [12:0] ctl_o;
    logic [1:0]  flag_clr_o;
    logic [1:0]  flag_i = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rap_port dut_i (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .ce_n(ce_n), .cmd_n(cmd_n),
        .rw(rw), .oe_n(oe_n), .lb_n(lb_n), .ub_n(ub_n), .addr(addr), .din(din),
        .dout(dout), .dout_en(dout_en), .conflict_o(conflict_o),
        .arr_addr_o(arr_addr_o), .arr_wdata_o(arr_wdata_o), .arr_we_o(arr_we_o),
        .arr_rdata_i(arr_rdata_i), .start1_o(start1_o), .end1_o(end1_o),
        .start2_o(start2_o), .end2_o(end2_o), .ctl_o(ctl_o),
        .flag_clr_o(flag_clr_o), .flag_i(flag_i)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive a cycle setting at the falling edge; outputs settle 1 ns later.
    task automatic setup(input logic c, input logic m, input logic r, input logic o,
                         input logic l, input logic u, input logic [11:0] a,
                         input logic [15:0] d, input logic s);
        @(negedge clk);
        ce_n = c; cmd_n = m; rw = r; oe_n = o; lb_n = l; ub_n = u;
        addr = a; din = d; wr_stb = s;
        #1;
    endtask

    task automatic park();
        setup(1, 1, 1, 1, 1, 1, 12'h0, 16'h0, 0);
    endtask

    task automatic reg_write(input logic [2:0] code, input logic [15:0] d);
        setup(1, 0, 0, 1, 1, 1, {9'h0, code}, d, 1);
    endtask

    task automatic reg_read(input logic [2:0] code, input logic [15:0] exp, input string req);
        setup(1, 0, 1, 0, 0, 0, {9'h0, code}, 16'h0, 0);
        chk(req, dout, exp);
        chk(req, dout_en, 16'hFFFF);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic t_reset();
        do_reset();
        park();
        chk("R10 start1", start1_o, 0); chk("R10 end1", end1_o, 0);
        chk("R10 start2", start2_o, 0); chk("R10 end2", end2_o, 0);
        chk("R10 ctl", ctl_o, 0);
        chk("R3 idle drive", dout_en, 0);
        reg_read(3'd5, 16'h0, "R10 ctl read");
    endtask

    task automatic t_pointers();
        reg_write(3'd0, 16'hF123);
        reg_write(3'd1, 16'hE456);
        reg_write(3'd2, 16'hD789);
        reg_write(3'd3, 16'hCABC);
        park();
        chk("R6 start1", start1_o, 12'h123); chk("R6 end1", end1_o, 12'h456);
        chk("R6 start2", start2_o, 12'h789); chk("R6 end2", end2_o, 12'hABC);
        reg_read(3'd0, 16'h0123, "R6 rd start1");
        reg_read(3'd3, 16'h0ABC, "R6 rd end2");
    endtask

    task automatic t_control();
        reg_write(3'd5, 16'hFFFF);
        chk("R8 no clear", flag_clr_o, 2'b00);
        park();
        chk("R7 ctl", ctl_o, 13'h1FFF);
        reg_read(3'd5, 16'h1FFF, "R7 rd ctl");
        reg_write(3'd5, 16'h0002);
        chk("R8 clear 1", flag_clr_o, 2'b01);
        reg_write(3'd5, 16'h0000);
        chk("R8 clear both", flag_clr_o, 2'b11);
        reg_write(3'd1, 16'h0000);
        chk("R8 other code", flag_clr_o, 2'b00);
        park();
        chk("R8 after strobe", flag_clr_o, 2'b00);
        reg_write(3'd1, 16'h0456);
    endtask

    task automatic t_flags();
        flag_i = 2'b10;
        reg_read(3'd6, 16'h0002, "R9 flag read");
        flag_i = 2'b01;
        reg_read(3'd6, 16'h0001, "R9 flag read b");
        reg_write(3'd4, 16'hFFFF);
        reg_write(3'd6, 16'hFFFF);
        reg_write(3'd7, 16'hFFFF);
        park();
        reg_read(3'd4, 16'h0, "R9 code4");
        reg_read(3'd7, 16'h0, "R9 code7");
        reg_read(3'd6, 16'h0001, "R9 flag after write");
        chk("R9 start1 kept", start1_o, 12'h123); chk("R9 end1 kept", end1_o, 12'h456);
        chk("R9 start2 kept", start2_o, 12'h789); chk("R9 end2 kept", end2_o, 12'hABC);
        chk("R9 ctl kept", ctl_o, 13'h0);
    endtask

    task automatic t_array_write();
        setup(0, 1, 0, 1, 0, 1, 12'hA5C, 16'hBEEF, 1);
        chk("R1 lower", arr_we_o, 2'b01);
        chk("R1 addr", arr_addr_o, 12'hA5C); chk("R1 data", arr_wdata_o, 16'hBEEF);
        setup(0, 1, 0, 1, 1, 0, 12'h001, 16'h1234, 1);
        chk("R1 upper", arr_we_o, 2'b10);
        setup(0, 1, 0, 0, 0, 0, 12'hFFF, 16'h1234, 1);
        chk("R1 both", arr_we_o, 2'b11);
        chk("R3 write no drive", dout_en, 0);
        setup(0, 1, 0, 1, 0, 0, 12'hFFF, 16'h1234, 0);
        chk("R1 no strobe", arr_we_o, 2'b00);
        setup(0, 1, 1, 1, 0, 0, 12'hFFF, 16'h1234, 1);
        chk("R1 read dir", arr_we_o, 2'b00);
        park();
    endtask

    task automatic t_array_read();
        arr_rdata_i = 16'hA55A;
        setup(0, 1, 1, 0, 0, 1, 12'h010, 16'h0, 0);
        chk("R2 low data", dout, 16'h005A); chk("R2 low en", dout_en, 16'h00FF);
        setup(0, 1, 1, 0, 1, 0, 12'h010, 16'h0, 0);
        chk("R2 up data", dout, 16'hA500); chk("R2 up en", dout_en, 16'hFF00);
        setup(0, 1, 1, 0, 0, 0, 12'h010, 16'h0, 0);
        chk("R2 both", dout, 16'hA55A); chk("R2 both en", dout_en, 16'hFFFF);
        setup(0, 1, 1, 1, 0, 0, 12'h010, 16'h0, 0);
        chk("R3 oe high en", dout_en, 0); chk("R3 oe high data", dout, 0);
        park();
    endtask

    task automatic t_idle_clash();
        setup(1, 1, 1, 0, 0, 0, 12'h000, 16'h0, 0);
        chk("R4 idle drive", dout_en, 0);
        setup(1, 1, 0, 1, 0, 0, 12'h000, 16'h0777, 1);
        chk("R4 idle we", arr_we_o, 0);
        setup(0, 0, 1, 0, 0, 0, 12'h000, 16'h0, 0);
        chk("R5 conflict", conflict_o, 1);
        chk("R5 no drive", dout_en, 0);
        setup(0, 0, 0, 1, 0, 0, 12'h000, 16'h0777, 1);
        chk("R5 no we", arr_we_o, 0);
        park();
        chk("R5 conflict gone", conflict_o, 0);
        chk("R4 R5 start1 kept", start1_o, 12'h123);
    endtask

    task automatic t_reg_lanes();
        setup(1, 0, 1, 0, 1, 1, 12'h002, 16'h0, 0);
        chk("R11 lanes off drive", dout_en, 16'hFFFF);
        chk("R11 data", dout, 16'h0789);
        park();
    endtask

    task automatic t_reset_again();
        do_reset();
        park();
        chk("R10 start2 cleared", start2_o, 0);
        chk("R10 end1 cleared", end1_o, 0);
    endtask

    initial begin
        t_reset();
        t_pointers();
        t_control();
        t_flags();
        t_array_write();
        t_array_read();
        t_idle_clash();
        t_reg_lanes();
        t_reset_again();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule